// File: doc/BRIEF.md
# Work Request and Completion Message Codec

This block translates between a 32-bit word stream coming from a host mailbox and the message-level view used by a processing pipeline. In the inbound direction it collects words into 128-bit work requests. It checks that each request has even parity across all 128 bits. It then hands the request handle and the 64-bit buffer address to the pipeline as a one-cycle pulse. A request that fails the parity check never reaches the pipeline, and it raises a flag that stays set.

In the outbound direction the pipeline presents the fields of a finished job in one handshake. The block packs them into a 512-bit completion. It derives the all-packets-arrived flag from the packet mask and places a parity bit so that the first 128 bits have even parity. The completion then leaves as sixteen 32-bit words under a valid/ready handshake. Words travel least-significant first in both directions.

Each direction runs its own two-state machine. The inbound machine has the states RX_COLLECT and RX_ISSUE. The move from RX_COLLECT to RX_ISSUE happens on the last word of a request whose parity is good. A last word with bad parity leaves the machine in RX_COLLECT. The machine always returns from RX_ISSUE to RX_COLLECT after one cycle. The outbound machine has the states TX_IDLE and TX_SEND. It moves from TX_IDLE to TX_SEND when a completion is accepted. It returns from TX_SEND to TX_IDLE when the last word is handshaken.

Top module: `msg_codec`

## Requirements
- R1: Four accepted inbound words form one request, with word 0 as bits 31:0. req_handle is bits 31:0. req_addr is bits 95:32, so word 1 is its low half and word 2 its high half. When parity is good, req_valid is high for exactly one cycle: the cycle after the fourth word is accepted.
- R2: in_ready is low in the cycle where req_valid is high and high in every other cycle after reset.
- R3: If the XOR of all 128 request bits is 1, no req_valid pulse is produced and par_err goes high. par_err stays high until reset, and the next good request is still decoded correctly.
- R4: While in reset and right after it, req_valid, out_valid and par_err are 0, and in_ready and cpl_ready are 1.
- R5: A completion leaves as 16 words, word 0 first. Word 0 is the handle. Word 1 holds the module number in bits 7:0, the all-OK flag in bit 8, the trigger in bit 9, zeros in bits 30:10 and the parity bit in bit 31. Words 2-3 are the frame number, words 4-5 the timestamp and words 6-7 the bunch ID, each low half first. Word 8 is the exposure time and word 9 the debug word. Word 10 is zero. Word 11 holds the collection ID in bits 15:0 with zeros above. Words 12-15 are the packet mask, bits 31:0 first.
- R6: The XOR of all bits of words 0 to 3 of every completion is 0.
- R7: The all-OK bit (word 1, bit 8) equals the AND of all 128 packet-mask bits.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data stays unchanged on the next cycle.
- R9: cpl_ready is low from the cycle after a completion is accepted until the last word is handshaken. It is high again in the cycle after that.
- R10: out_valid rises, carrying word 0, in the cycle right after cpl_valid and cpl_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inbound word valid |
| in_ready | output | 1 | Inbound word accepted when high with in_valid |
| in_data | input | 32 | Inbound word |
| req_valid | output | 1 | One-cycle pulse: a good request is available |
| req_handle | output | 32 | Request handle, valid with req_valid |
| req_addr | output | 64 | Request buffer address, valid with req_valid |
| par_err | output | 1 | Sticky: a request with odd parity was dropped |
| cpl_valid | input | 1 | Completion fields valid |
| cpl_ready | output | 1 | Completion fields accepted when high with cpl_valid |
| cpl_handle | input | 32 | Handle to echo |
| cpl_module | input | 8 | Module number |
| cpl_trigger | input | 1 | Trigger flag |
| cpl_frame | input | 64 | Frame number |
| cpl_timestamp | input | 64 | Timestamp |
| cpl_bunch | input | 64 | Bunch ID |
| cpl_exptime | input | 32 | Exposure time |
| cpl_debug | input | 32 | Debug word |
| cpl_dcid | input | 16 | Data collection ID |
| cpl_mask | input | 128 | Packet mask, 1 = packet arrived |
| out_valid | output | 1 | Outbound word valid |
| out_ready | input | 1 | Outbound word taken |
| out_data | output | 32 | Outbound word |

## Verification
The bench builds the block with its default WORD_W of 32. At that width a request is 4 words and a completion 16. These counts put the word-3 parity boundary, the word-1 flag layout and the 16th-word release of cpl_ready within reach of directed sequences. The request patterns include good messages, a message whose parity bit is flipped, and a good message right after that one. The completion patterns use both a full and a gapped packet mask, with and without sink back-pressure.

// File: rtl/msg_codec_pkg.sv
package msg_codec_pkg;

    localparam int REQ_BITS = 128;
    localparam int CPL_BITS = 512;

    typedef enum logic {RX_COLLECT, RX_ISSUE} rx_state_e;
    typedef enum logic {TX_IDLE, TX_SEND} tx_state_e;

    typedef struct packed {
        logic [31:0]  handle;
        logic [7:0]   module_no;
        logic         trigger;
        logic [63:0]  frame;
        logic [63:0]  stamp;
        logic [63:0]  bunch;
        logic [31:0]  exptime;
        logic [31:0]  debug;
        logic [15:0]  dcid;
        logic [127:0] mask;
    } cpl_fields_t;

endpackage

// File: rtl/msg_req_rx.sv
module msg_req_rx
    import msg_codec_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              req_valid,
    output logic [31:0]       req_handle,
    output logic [63:0]       req_addr,
    output logic              par_err
);
    localparam int REQ_WORDS = REQ_BITS / WORD_W;
    localparam int CNT_W     = (REQ_WORDS > 1) ? $clog2(REQ_WORDS) : 1;

    rx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [REQ_BITS-1:0]  gather_q;
    logic [REQ_BITS-1:0]  full_msg;
    logic                 take, last_word, parity_ok;
    logic                 par_err_q;

    assign take      = in_valid && in_ready;
    assign last_word = take && (cnt_q == CNT_W'(REQ_WORDS - 1));
    assign full_msg  = {in_data, gather_q[REQ_BITS-1:WORD_W]};
    assign parity_ok = ~(^full_msg);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_COLLECT;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_COLLECT: if (last_word && parity_ok) state_d = RX_ISSUE;
            RX_ISSUE:   state_d = RX_COLLECT;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        req_valid = 1'b0;
        unique case (state_q)
            RX_COLLECT: in_ready  = 1'b1;
            RX_ISSUE:   req_valid = 1'b1;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            gather_q  <= '0;
            par_err_q <= 1'b0;
        end else if (take) begin
            gather_q <= full_msg;
            cnt_q    <= last_word ? '0 : cnt_q + 1'b1;
            if (last_word && !parity_ok) par_err_q <= 1'b1;
        end
    end

    assign req_handle = gather_q[31:0];
    assign req_addr   = gather_q[95:32];
    assign par_err    = par_err_q;

endmodule

// File: rtl/msg_cpl_pack.sv
module msg_cpl_pack
    import msg_codec_pkg::*;
(
    input  cpl_fields_t          fields,
    output logic [CPL_BITS-1:0]  msg
);
    logic [CPL_BITS-1:0] body;

    always_comb begin
        body          = '0;
        body[31:0]    = fields.handle;
        body[39:32]   = fields.module_no;
        body[40]      = &fields.mask;
        body[41]      = fields.trigger;
        body[127:64]  = fields.frame;
        body[191:128] = fields.stamp;
        body[255:192] = fields.bunch;
        body[287:256] = fields.exptime;
        body[319:288] = fields.debug;
        body[367:352] = fields.dcid;
        body[511:384] = fields.mask;
    end

    // bit 63 is zero in body, so its parity bit is the XOR of the first quarter
    always_comb begin
        msg     = body;
        msg[63] = ^body[127:0];
    end

endmodule

// File: rtl/msg_cpl_tx.sv
module msg_cpl_tx
    import msg_codec_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cpl_valid,
    output logic                cpl_ready,
    input  logic [CPL_BITS-1:0] msg_in,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data
);
    localparam int CPL_WORDS = CPL_BITS / WORD_W;
    localparam int CNT_W     = (CPL_WORDS > 1) ? $clog2(CPL_WORDS) : 1;

    tx_state_e            state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [CPL_BITS-1:0]  sh_q;
    logic                 load, beat, last_beat;

    assign load      = cpl_valid && cpl_ready;
    assign beat      = out_valid && out_ready;
    assign last_beat = beat && (cnt_q == CNT_W'(CPL_WORDS - 1));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load)      state_d = TX_SEND;
            TX_SEND: if (last_beat) state_d = TX_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        cpl_ready = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            TX_IDLE: cpl_ready = 1'b1;
            TX_SEND: out_valid = 1'b1;
        endcase
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (load) begin
            cnt_q <= '0;
            sh_q  <= msg_in;
        end else if (beat) begin
            cnt_q <= last_beat ? '0 : cnt_q + 1'b1;
            sh_q  <= {{WORD_W{1'b0}}, sh_q[CPL_BITS-1:WORD_W]};
        end
    end

    assign out_data = sh_q[WORD_W-1:0];

endmodule

// File: rtl/msg_codec.sv
module msg_codec
    import msg_codec_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    output logic              req_valid,
    output logic [31:0]       req_handle,
    output logic [63:0]       req_addr,
    output logic              par_err,
    input  logic              cpl_valid,
    output logic              cpl_ready,
    input  logic [31:0]       cpl_handle,
    input  logic [7:0]        cpl_module,
    input  logic              cpl_trigger,
    input  logic [63:0]       cpl_frame,
    input  logic [63:0]       cpl_timestamp,
    input  logic [63:0]       cpl_bunch,
    input  logic [31:0]       cpl_exptime,
    input  logic [31:0]       cpl_debug,
    input  logic [15:0]       cpl_dcid,
    input  logic [127:0]      cpl_mask,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data
);
    cpl_fields_t         fields;
    logic [CPL_BITS-1:0] packed_msg;

    assign fields = '{handle:    cpl_handle,
                      module_no: cpl_module,
                      trigger:   cpl_trigger,
                      frame:     cpl_frame,
                      stamp:     cpl_timestamp,
                      bunch:     cpl_bunch,
                      exptime:   cpl_exptime,
                      debug:     cpl_debug,
                      dcid:      cpl_dcid,
                      mask:      cpl_mask};

    msg_req_rx #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .req_valid  (req_valid),
        .req_handle (req_handle),
        .req_addr   (req_addr),
        .par_err    (par_err)
    );

    msg_cpl_pack u_pack (
        .fields (fields),
        .msg    (packed_msg)
    );

    msg_cpl_tx #(.WORD_W(WORD_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpl_valid (cpl_valid),
        .cpl_ready (cpl_ready),
        .msg_in    (packed_msg),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: rtl/msg_codec_chk.sv
module msg_codec_chk
    import msg_codec_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              req_valid,
    input logic              par_err,
    input logic              cpl_valid,
    input logic              cpl_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [WORD_W-1:0] out_data
);
    localparam int REQ_WORDS = REQ_BITS / WORD_W;
    localparam int CPL_WORDS = CPL_BITS / WORD_W;
    localparam int IDX_W     = $clog2(CPL_WORDS) + 1;

    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] acc_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (out_valid && out_ready) begin
            idx_q <= (idx_q == IDX_W'(CPL_WORDS - 1)) ? '0 : idx_q + 1'b1;
            if (idx_q < IDX_W'(REQ_WORDS - 1))       acc_q <= acc_q ^ out_data;
            else if (idx_q == IDX_W'(REQ_WORDS - 1)) acc_q <= '0;
        end
    end

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R1
    AST_REQ_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !in_ready); // R2
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        par_err |=> par_err); // R3
    AST_CPL_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && idx_q == IDX_W'(REQ_WORDS - 1))
            |-> ((^acc_q) ^ (^out_data)) == 1'b0); // R6
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !cpl_ready); // R9
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl_valid && cpl_ready) |=> out_valid); // R10

endmodule

bind msg_codec msg_codec_chk #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .req_valid (req_valid),
    .par_err   (par_err),
    .cpl_valid (cpl_valid),
    .cpl_ready (cpl_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/msg_codec_tb.sv
`timescale 1ns/1ps
module msg_codec_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_data = '0;
    logic         req_valid;
    logic [31:0]  req_handle;
    logic [63:0]  req_addr;
    logic         par_err;
    logic         cpl_valid = 1'b0;
    logic         cpl_ready;
    logic [31:0]  cpl_handle = '0;
    logic [7:0]   cpl_module = '0;
    logic         cpl_trigger = 1'b0;
    logic [63:0]  cpl_frame = '0;
    logic [63:0]  cpl_timestamp = '0;
    logic [63:0]  cpl_bunch = '0;
    logic [31:0]  cpl_exptime = '0;
    logic [31:0]  cpl_debug = '0;
    logic [15:0]  cpl_dcid = '0;
    logic [127:0] cpl_mask = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [31:0]  out_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    msg_codec u_dut (.*);

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk(req_valid == 1'b0, "R4 req_valid", 64'(req_valid), 0);
        chk(out_valid == 1'b0, "R4 out_valid", 64'(out_valid), 0);
        chk(par_err == 1'b0,   "R4 par_err",   64'(par_err), 0);
        chk(in_ready == 1'b1,  "R4 in_ready",  64'(in_ready), 1);
        chk(cpl_ready == 1'b1, "R4 cpl_ready", 64'(cpl_ready), 1);
    endtask

    // sends a request; flip = 1 corrupts the parity bit
    task automatic send_req(input logic [31:0] h, input logic [63:0] a,
                            input logic [30:0] upper, input bit flip);
        logic [31:0] w [4];
        logic        p;
        p = ^{h, a, upper} ^ flip;
        w[0] = h; w[1] = a[31:0]; w[2] = a[63:32]; w[3] = {upper, p};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_data  = w[i];
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic test_req_good(input logic [31:0] h, input logic [63:0] a,
                                 input logic [30:0] upper);
        send_req(h, a, upper, 1'b0);
        chk(req_valid == 1'b1, "R1 req_valid pulse", 64'(req_valid), 1);
        chk(req_handle == h,   "R1 handle", 64'(req_handle), 64'(h));
        chk(req_addr == a,     "R1 address", req_addr, a);
        chk(in_ready == 1'b0,  "R2 in_ready low in issue cycle", 64'(in_ready), 0);
        @(negedge clk);
        chk(req_valid == 1'b0, "R1 pulse is single cycle", 64'(req_valid), 0);
        chk(in_ready == 1'b1,  "R2 in_ready back high", 64'(in_ready), 1);
    endtask

    task automatic test_req_bad();
        send_req(32'h0BAD_0BAD, 64'hDEAD_BEEF_0000_1111, 31'h0055_AA55, 1'b1);
        chk(req_valid == 1'b0, "R3 no pulse on bad parity", 64'(req_valid), 0);
        chk(par_err == 1'b1,   "R3 par_err set", 64'(par_err), 1);
        @(negedge clk);
        chk(req_valid == 1'b0, "R3 still no pulse", 64'(req_valid), 0);
        test_req_good(32'h1357_9BDF, 64'hFEDC_BA98_7654_3210, 31'h1);
        chk(par_err == 1'b1,   "R3 par_err sticky", 64'(par_err), 1);
    endtask

    task automatic test_cpl(input logic [31:0] h, input logic [7:0] m, input bit trig,
                            input logic [63:0] fr, input logic [63:0] ts,
                            input logic [63:0] bn, input logic [31:0] ex,
                            input logic [31:0] dbg, input logic [15:0] dc,
                            input logic [127:0] mk, input bit stall);
        logic [31:0] e [16];
        logic [31:0] got;
        logic [31:0] held;
        logic        ok_bit, p, xr;
        ok_bit = &mk;
        p      = ^{h, m, ok_bit, trig, fr};
        e[0] = h; e[1] = {p, 21'b0, trig, ok_bit, m};
        e[2] = fr[31:0]; e[3] = fr[63:32];
        e[4] = ts[31:0]; e[5] = ts[63:32];
        e[6] = bn[31:0]; e[7] = bn[63:32];
        e[8] = ex; e[9] = dbg; e[10] = '0; e[11] = {16'b0, dc};
        e[12] = mk[31:0]; e[13] = mk[63:32]; e[14] = mk[95:64]; e[15] = mk[127:96];

        @(negedge clk);
        chk(cpl_ready == 1'b1, "R9 cpl_ready idle", 64'(cpl_ready), 1);
        cpl_handle = h; cpl_module = m; cpl_trigger = trig; cpl_frame = fr;
        cpl_timestamp = ts; cpl_bunch = bn; cpl_exptime = ex; cpl_debug = dbg;
        cpl_dcid = dc; cpl_mask = mk; cpl_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpl_valid = 1'b0;
        chk(out_valid == 1'b1, "R10 out_valid next cycle", 64'(out_valid), 1);
        xr = 1'b0;
        for (int k = 0; k < 16; k++) begin
            if (stall && (k % 3 == 0)) begin
                out_ready = 1'b0;
                held = out_data;
                @(posedge clk);
                @(negedge clk);
                chk(out_valid == 1'b1 && out_data == held, "R8 hold under stall",
                    64'(out_data), 64'(held));
            end
            got = out_data;
            chk(got == e[k], $sformatf("R5 word %0d", k), 64'(got), 64'(e[k]));
            chk(cpl_ready == 1'b0, "R9 cpl_ready low while sending", 64'(cpl_ready), 0);
            if (k < 4) xr = xr ^ (^got);
            if (k == 1) chk(got[8] == ok_bit, "R7 all-ok bit", 64'(got[8]), 64'(ok_bit));
            out_ready = 1'b1;
            @(posedge clk);
            @(negedge clk);
            out_ready = 1'b0;
        end
        chk(xr == 1'b0, "R6 first quarter even parity", 64'(xr), 0);
        chk(out_valid == 1'b0, "R9 out_valid drops after last", 64'(out_valid), 0);
        chk(cpl_ready == 1'b1, "R9 cpl_ready back high", 64'(cpl_ready), 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        test_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_req_good(32'hA5A5_0001, 64'h0123_4567_89AB_CDEF, 31'h1234_5678);
        test_req_good(32'hFFFF_FFFF, 64'h0, 31'h0);
        test_req_bad();
        test_cpl(32'hCAFE_0001, 8'h2A, 1'b1, 64'h1111_2222_3333_4444,
                 64'h5555_6666_7777_8888, 64'h9999_AAAA_BBBB_CCCC, 32'h0000_1388,
                 32'hD1D2_D3D4, 16'hBEEF, {128{1'b1}}, 1'b0);
        test_cpl(32'h0000_0007, 8'h05, 1'b0, 64'h0000_0000_0000_0003,
                 64'h0102_0304_0506_0708, 64'h0, 32'hFFFF_FFFF,
                 32'h0, 16'h0042, ~(128'h1 << 77), 1'b1);
        test_cpl(32'h8000_0000, 8'hFF, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF,
                 64'h0, 64'h1, 32'h1, 32'h2, 16'hFFFF, 128'h0, 1'b1);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule